// File: doc/BRIEF.md
# Compressed Data Burst Preamble Detector

This block sits behind a receiver that has already decoded the incoming IEC 60958 stream into subframes. It decides whether that stream carries encoded non-audio data rather than linear PCM samples, and drives one flag that a downstream controller can watch. For example, the controller can use the flag to keep the converters quiet while compressed data is present.

Two independent triggers raise the flag. The first is the received channel status non-audio indicator. The second is a burst sync pattern inside the sample words: two sync words in adjacent subframes, preceded by a run of silent subframes. After a trigger the flag stays high for a fixed window, counted in frames, so that short gaps between bursts do not make it flicker.

Top module: `burst_sync_detector`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the flag, the silent-run count and the hold count. After reset the flag is low, and a silent run built before reset does not count.
- R2: A clock edge that samples cs_nonaudio high raises data_flag after that edge. The flag stays high while cs_nonaudio remains high.
- R3: A sync pair is a subframe whose upper 16 bits (samp_data[23:8]) equal F872h, followed in the very next valid subframe by one whose upper 16 bits equal 4E1Fh. When such a pair is preceded by at least 4 silent subframes, data_flag is high after the edge that samples the second word.
- R4: A silent subframe has all 24 bits zero. With 0 to 3 silent subframes before the pair, nothing is detected. Any non-silent subframe, including one whose only set bits lie in samp_data[7:0], restarts the run. The run count saturates at 4.
- R5: Bits samp_data[7:0] take no part in the comparison with the sync words.
- R6: The two sync words must sit in adjacent valid subframes and in the stated order. A subframe between them, or the words in reverse order, gives no detection.
- R7: Valid subframes must alternate chan_right (0 = left, 1 = right). Two consecutive valid subframes with the same chan_right value mark a break. The run restarts at the second subframe (it counts as 1 if silent), and a pending first sync word is discarded.
- R8: After the last trigger, data_flag stays high for exactly 4096 frame_stb pulses and is low after the 4096th.
- R9: A new detection during the hold window restarts the full 4096-frame window.
- R10: Once cs_nonaudio returns low, the flag stays high for 4096 further frame strobes and then falls.
- R11: A frame_stb in the same cycle as a trigger does not shorten the window. The reload takes precedence over the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_vld | input | 1 | One-cycle strobe marking a decoded subframe on samp_data |
| samp_data | input | 24 | Decoded 24-bit subframe sample |
| chan_right | input | 1 | Channel of the current subframe: 0 left, 1 right |
| frame_stb | input | 1 | One pulse per left+right frame |
| cs_nonaudio | input | 1 | Received channel status non-audio indicator |
| data_flag | output | 1 | High while non-audio data is detected or held |

## Verification
The assertions take for granted that every input changes synchronously with clk. They also assume that frame_stb pulses at most once per frame, and that cs_nonaudio is a level held by the upstream status logic, not a glitch. The properties only relate the flag to its causes: a trigger raises it, and without a strobe it cannot fall. Because of this, they stay valid whatever order of subframes arrives. The stimulus drives all inputs on the falling edge. It pulses frame_stb together with each right-channel subframe and alternates channels, except where a break is injected on purpose. It sweeps silent-run lengths from 0 to 7 before each sync pair.

// File: rtl/burst_det_pkg.sv
`timescale 1ns/1ps
package burst_det_pkg;

  localparam int SAMPLE_W = 24;
  localparam int SYNC_W   = 16;

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [SYNC_W-1:0]   sync_t;

  localparam sync_t SYNC_FIRST  = 16'hF872;
  localparam sync_t SYNC_SECOND = 16'h4E1F;

  // Upper part of the sample that carries the sync word.
  function automatic sync_t sync_field(input sample_t s);
    return s[SAMPLE_W-1 -: SYNC_W];
  endfunction

  function automatic logic is_silent(input sample_t s);
    return (s == '0);
  endfunction

  // Next silent-run length for one accepted subframe.
  function automatic int run_next(input int cur, input int lim,
                                  input logic silent, input logic brk);
    if (brk)     return silent ? 1 : 0;
    if (!silent) return 0;
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // Next hold count: a trigger reloads, a frame strobe counts down.
  function automatic int hold_next(input int cur, input int top,
                                   input logic load, input logic tick);
    if (load)             return top;
    if (tick && cur != 0) return cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/bdd_chan_track.sv
`timescale 1ns/1ps
module bdd_chan_track (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic chan_right,
  output logic brk
);
  logic seen_q;
  logic last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      last_q <= 1'b0;
    end else if (vld) begin
      seen_q <= 1'b1;
      last_q <= chan_right;
    end
  end

  assign brk = vld && seen_q && (chan_right == last_q);
endmodule

// File: rtl/bdd_zero_run.sv
`timescale 1ns/1ps
module bdd_zero_run import burst_det_pkg::*; #(
  parameter int MIN_ZERO = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic silent,
  input  logic brk,
  output logic run_ok
);
  localparam int ZCW = $clog2(MIN_ZERO + 1);

  logic [ZCW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)
      run_q <= '0;
    else if (vld)
      run_q <= ZCW'(run_next(int'(run_q), MIN_ZERO, silent, brk));
  end

  assign run_ok = (int'(run_q) >= MIN_ZERO);
endmodule

// File: rtl/bdd_pair_match.sv
`timescale 1ns/1ps
module bdd_pair_match import burst_det_pkg::*; #(
  parameter sync_t WORD_A = SYNC_FIRST,
  parameter sync_t WORD_B = SYNC_SECOND
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  vld,
  input  logic  brk,
  input  logic  run_ok,
  input  sync_t word,
  output logic  hit
);
  logic armed_q;
  logic is_a;
  logic is_b;

  assign is_a = (word == WORD_A);
  assign is_b = (word == WORD_B);

  always_ff @(posedge clk) begin
    if (rst)
      armed_q <= 1'b0;
    else if (vld)
      armed_q <= is_a && run_ok && !brk;
  end

  assign hit = vld && !brk && armed_q && is_b;
endmodule

// File: rtl/bdd_hold_timer.sv
`timescale 1ns/1ps
module bdd_hold_timer import burst_det_pkg::*; #(
  parameter int HOLD_FRAMES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic active
);
  localparam int HCW = $clog2(HOLD_FRAMES + 1);

  logic [HCW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else
      cnt_q <= HCW'(hold_next(int'(cnt_q), HOLD_FRAMES, load, tick));
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/burst_sync_detector.sv
`timescale 1ns/1ps
module burst_sync_detector import burst_det_pkg::*; #(
  parameter int    MIN_ZERO    = 4,
  parameter int    HOLD_FRAMES = 4096,
  parameter sync_t WORD_A      = SYNC_FIRST,
  parameter sync_t WORD_B      = SYNC_SECOND
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                samp_vld,
  input  logic [SAMPLE_W-1:0] samp_data,
  input  logic                chan_right,
  input  logic                frame_stb,
  input  logic                cs_nonaudio,
  output logic                data_flag
);
  // Named internal events, also observed by the bound checker.
  logic  restart;
  logic  run_ok;
  logic  sync_hit;
  logic  trigger;
  logic  silent;
  sync_t word;

  assign silent  = is_silent(samp_data);
  assign word    = sync_field(samp_data);
  assign trigger = sync_hit || cs_nonaudio;

  bdd_chan_track u_chan (
    .clk        (clk),
    .rst        (rst),
    .vld        (samp_vld),
    .chan_right (chan_right),
    .brk        (restart)
  );

  bdd_zero_run #(.MIN_ZERO(MIN_ZERO)) u_run (
    .clk    (clk),
    .rst    (rst),
    .vld    (samp_vld),
    .silent (silent),
    .brk    (restart),
    .run_ok (run_ok)
  );

  bdd_pair_match #(.WORD_A(WORD_A), .WORD_B(WORD_B)) u_pair (
    .clk    (clk),
    .rst    (rst),
    .vld    (samp_vld),
    .brk    (restart),
    .run_ok (run_ok),
    .word   (word),
    .hit    (sync_hit)
  );

  bdd_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load   (trigger),
    .tick   (frame_stb),
    .active (data_flag)
  );
endmodule

// File: rtl/bdd_checker.sv
`timescale 1ns/1ps
module bdd_checker (
  input logic clk,
  input logic rst,
  input logic samp_vld,
  input logic frame_stb,
  input logic cs_nonaudio,
  input logic data_flag,
  input logic sync_hit,
  input logic restart
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> !data_flag);

  p_status_raises_r2: assert property (@(posedge clk) disable iff (rst)
    cs_nonaudio |=> data_flag);

  p_hit_raises_r3: assert property (@(posedge clk) disable iff (rst)
    sync_hit |=> data_flag);

  p_hit_on_subframe_r6: assert property (@(posedge clk) disable iff (rst)
    sync_hit |-> samp_vld);

  p_break_blocks_hit_r7: assert property (@(posedge clk) disable iff (rst)
    restart |-> !sync_hit);

  p_fall_on_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (data_flag && !frame_stb) |=> data_flag);

  p_rise_needs_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (!data_flag && !sync_hit && !cs_nonaudio) |=> !data_flag);
endmodule

bind burst_sync_detector bdd_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .samp_vld    (samp_vld),
  .frame_stb   (frame_stb),
  .cs_nonaudio (cs_nonaudio),
  .data_flag   (data_flag),
  .sync_hit    (sync_hit),
  .restart     (restart)
);

// File: tb/sim_burst_sync_detector.sv
`timescale 1ns/1ps
module sim_burst_sync_detector;
  localparam int         HOLD = 4096;
  localparam logic [23:0] WA  = 24'hF87200;
  localparam logic [23:0] WB  = 24'h4E1F00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vld = 1'b0;
  logic [23:0] data = '0;
  logic        chr = 1'b0;
  logic        fs = 1'b0;
  logic        cs = 1'b0;
  logic        flag;
  bit          nxt_r = 1'b0;
  int          checks = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  burst_sync_detector u0 (
    .clk (clk), .rst (rst), .samp_vld (vld), .samp_data (data),
    .chan_right (chr), .frame_stb (fs), .cs_nonaudio (cs), .data_flag (flag)
  );

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (flag !== exp) begin
      fails++;
      $display("FAIL %s: data_flag=%0b expected %0b", tag, flag, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; vld = 1'b0; fs = 1'b0; cs = 1'b0; data = '0; chr = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0;
    nxt_r = 1'b0;
  endtask

  task automatic sub_ch(input logic [23:0] d, input bit r);
    @(negedge clk);
    vld = 1'b1; data = d; chr = r; fs = r;
    nxt_r = !r;
    @(posedge clk); #1;
  endtask

  task automatic sub(input logic [23:0] d);
    sub_ch(d, nxt_r);
  endtask

  task automatic idle();
    @(negedge clk);
    vld = 1'b0; fs = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) sub(24'h000000);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      sub(24'h123456);
      sub(24'h654321);
    end
  endtask

  // Counts HOLD-1 strobes (still high), then one more (low).
  task automatic hold_window(input string tag);
    frames(HOLD - 1);
    chk(1'b1, {tag, " high before last strobe"});
    frames(1);
    chk(1'b0, {tag, " low after last strobe"});
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    // R1: reset state
    do_reset();
    idle();
    chk(1'b0, "R1 flag after reset");

    // R3/R4 sweep over silent-run length
    for (int n = 0; n < 8; n++) begin
      do_reset();
      zeros(n);
      sub(WA);
      sub(WB);
      chk(n >= 4, $sformatf("R3 R4 run of %0d silent subframes", n));
      idle();
    end

    // R5: low byte ignored for sync compare
    do_reset();
    zeros(4); sub(24'hF872AB); sub(24'h4E1F01);
    chk(1'b1, "R5 sync with nonzero low byte");

    // R4: low-byte-only data breaks the run
    do_reset();
    zeros(4); sub(24'h000001); zeros(3); sub(WA); sub(WB);
    chk(1'b0, "R4 low-byte data restarts run");

    // R6: gap between words, and reversed order
    do_reset();
    zeros(4); sub(WA); sub(24'h000000); sub(WB);
    chk(1'b0, "R6 subframe between sync words");
    do_reset();
    zeros(4); sub(WB); sub(WA); sub(WB);
    chk(1'b0, "R6 reversed sync order");

    // R7: channel repeat breaks the run
    do_reset();
    sub_ch(0, 0); sub_ch(0, 1); sub_ch(0, 1); sub_ch(0, 0); sub(WA); sub(WB);
    chk(1'b0, "R7 repeat leaves run of 2");
    do_reset();
    sub_ch(0, 0); sub_ch(0, 1); sub_ch(0, 1); zeros(3); sub(WA); sub(WB);
    chk(1'b1, "R7 run restarted and rebuilt to 4");
    do_reset();
    zeros(4); sub_ch(WA, 0); sub_ch(WB, 0);
    chk(1'b0, "R7 repeat between sync words");

    // R1: run built before reset does not survive
    do_reset();
    zeros(5); do_reset(); sub(WA); sub(WB);
    chk(1'b0, "R1 run cleared by reset");

    // R8 + R11: exact hold; B lands on right subframe with frame strobe
    do_reset();
    zeros(4); sub(WA); sub(WB);
    chk(1'b1, "R3 detect before hold");
    hold_window("R8 R11 hold");

    // R1: reset clears an active flag
    zeros(4); sub(WA); sub(WB);
    do_reset(); idle();
    chk(1'b0, "R1 reset clears active flag");

    // R9: retrigger reloads the window
    zeros(4); sub(WA); sub(WB);
    frames(100);
    zeros(4); sub(WA); sub(WB);
    chk(1'b1, "R9 retrigger");
    hold_window("R9 reloaded hold");

    // R2 + R10: status bit
    do_reset();
    @(negedge clk); cs = 1'b1;
    @(posedge clk); #1;
    chk(1'b1, "R2 flag after status bit");
    for (int i = 0; i < 50; i++) begin
      frames(1);
      chk(1'b1, "R2 held while status bit high");
    end
    @(negedge clk); cs = 1'b0; vld = 1'b0; fs = 1'b0;
    @(posedge clk); #1;
    hold_window("R10 hold after status clears");

    finish_up();
  end
endmodule